// File: doc/BRIEF.md
# Open-Row DRAM Access Timer

This block stands in for one DRAM bank that keeps a single row open in a row buffer. It takes one command at a time: a load, a store or a flush. Each command comes with a byte address, store data, a tag and the number of the requesting core. The block reports completion after a delay worked out from two delay values that can be set at run time: one row-access delay and one column-access delay. A command that hits the open row costs less than one that has to open another row. A row that was changed by a store is written back to the array only when another row has to be opened, or when a flush is issued.

The array has a parameterised number of rows, each holding 256 words of 32 bits. The open row is kept in registers. A consecutive-hit count and a count of row-buffer updates are brought out for the scheduler around the block. On completion the block gives a one-cycle pulse that carries the word read or stored, together with the tag and core number captured when the command was accepted.

Top module: `rowbuf_dram_ctrl`

## Requirements
- R1: The byte address splits into row = address bits [ADDR_W-1:10] and word column = bits [9:2]. Bits [1:0] are ignored, so an address with those bits set reaches the same word.
- R2: A load or store to the open row completes 1 + column-delay cycles after the accepting edge.
- R3: A load or store to another row completes in 1 + column-delay + row-delay cycles when the open row is clean, or when no row is open (the state after reset).
- R4: When the open row is dirty, changing to another row costs one more row-delay, and the old row's contents are kept in the array.
- R5: On completion, a load returns the stored word, a store returns its own write data and a flush returns 0. Each completion carries the tag and core number of its command.
- R6: The hit counter becomes 1 when a row is opened and goes up by 1 on each load or store to the open row. Flush leaves it unchanged.
- R7: The row-update counter goes up by 1 for each row opened and by 1 for each store.
- R8: Command encoding: cmd_op 2'b00 is a load, 2'b01 is a store and 2'b1x is a flush. A flush of a dirty row takes 1 + row-delay cycles and leaves the row clean. A flush of a clean row takes 1 cycle.
- R9: cmd_ready is low from the accepting edge until completion, and commands offered during that time have no effect. done_valid lasts exactly one cycle.
- R10: After reset: cmd_ready is 1, done_valid is 0, both counters are 0 and no row is open.
- R11: The delay inputs are sampled when a command is accepted, so new values apply to the next command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_row_dly | input | DLY_W | Row-access delay in cycles |
| cfg_col_dly | input | DLY_W | Column-access delay in cycles |
| cmd_valid | input | 1 | A command is offered |
| cmd_ready | output | 1 | Idle; a command is accepted when valid and ready are both high |
| cmd_op | input | 2 | 00 load, 01 store, 1x flush |
| cmd_addr | input | ADDR_W | Byte address |
| cmd_wdata | input | 32 | Store data |
| cmd_tag | input | TAG_W | Load tag returned on completion |
| cmd_core | input | CORE_W | Requesting core number |
| done_valid | output | 1 | One-cycle completion pulse |
| done_rdata | output | 32 | Word read or stored |
| done_tag | output | TAG_W | Tag of the completed command |
| done_core | output | CORE_W | Core of the completed command |
| hit_count | output | HIT_W | Consecutive accesses to the open row |
| row_updates | output | UPD_W | Row openings plus stores |

## Verification
The first access after reset tells a missing-row start apart from a false writeback. Repeated accesses to one row, one of them with the low address bits set, exercise the hit path. Alternating stores between two rows separate the clean-miss cost from the dirty-miss cost, and reloading the first row afterwards shows whether the writeback kept its data. Flushes of a dirty row and then of a clean row, commands offered while busy, and a change of both delays between commands each isolate one timing rule.

// File: rtl/drb_pkg.sv
package drb_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'b00,
    OP_STORE  = 2'b01,
    OP_FLUSH  = 2'b10,
    OP_FLUSH2 = 2'b11
  } drb_op_e;

  localparam int WORD_BITS     = 32;
  localparam int WORDS_PER_ROW = 256;
  localparam int ROW_SHIFT     = 10;
endpackage

// File: rtl/drb_access_plan.sv
module drb_access_plan #(
  parameter int ROW_W = 3
) (
  input  logic [1:0]       op,
  input  logic [ROW_W-1:0] row,
  input  logic             open_valid,
  input  logic [ROW_W-1:0] open_row,
  input  logic             open_dirty,
  output logic             hit,
  output logic             activate,
  output logic             writeback,
  output logic             is_store,
  output logic             is_flush
);
  always_comb begin
    is_flush  = op[1];
    is_store  = !op[1] && op[0];
    hit       = open_valid && (open_row == row);
    activate  = !is_flush && !hit;
    writeback = open_valid && open_dirty && (is_flush || !hit);
  end
endmodule

// File: rtl/drb_busy_timer.sv
module drb_busy_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             activate,
  input  logic             writeback,
  input  logic             is_flush,
  input  logic [DLY_W-1:0] row_dly,
  input  logic [DLY_W-1:0] col_dly,
  output logic             idle,
  output logic             finish
);
  localparam int CNT_W = DLY_W + 2;

  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] access_cycles(
    input logic act, input logic wb, input logic fl,
    input logic [DLY_W-1:0] rd, input logic [DLY_W-1:0] cd);
    logic [CNT_W-1:0] t;
    t = CNT_W'(1);
    if (!fl) t = t + CNT_W'(cd);
    if (act) t = t + CNT_W'(rd);
    if (wb)  t = t + CNT_W'(rd);
    return t;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      finish <= 1'b0;
    end else begin
      finish <= (cnt_q == CNT_W'(1));
      if (start)
        cnt_q <= access_cycles(activate, writeback, is_flush, row_dly, col_dly);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign idle = (cnt_q == '0);
endmodule

// File: rtl/drb_row_store.sv
module drb_row_store #(
  parameter int NUM_ROWS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic                          activate,
  input  logic                          writeback,
  input  logic                          is_store,
  input  logic                          is_flush,
  input  logic [$clog2(NUM_ROWS)-1:0]   row,
  input  logic [7:0]                    col,
  input  logic [drb_pkg::WORD_BITS-1:0] wdata,
  output logic                          open_valid,
  output logic [$clog2(NUM_ROWS)-1:0]   open_row,
  output logic                          open_dirty,
  output logic [drb_pkg::WORD_BITS-1:0] rd_word
);
  localparam int ROW_W    = $clog2(NUM_ROWS);
  localparam int DW       = drb_pkg::WORD_BITS;
  localparam int ROW_BITS = drb_pkg::WORDS_PER_ROW * DW;

  logic [ROW_BITS-1:0] mem_q [NUM_ROWS];
  logic [ROW_BITS-1:0] buf_q;
  logic [ROW_BITS-1:0] line_src;
  logic [ROW_BITS-1:0] line_new;

  function automatic logic [DW-1:0] pick_word(input logic [ROW_BITS-1:0] line,
                                              input logic [7:0] c);
    return line[int'(c)*DW +: DW];
  endfunction

  always_comb begin
    line_src = activate ? mem_q[row] : buf_q;
    line_new = line_src;
    if (is_store) line_new[int'(col)*DW +: DW] = wdata;
  end

  always_ff @(posedge clk) begin
    if (start && writeback) mem_q[open_row] <= buf_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q      <= '0;
      open_valid <= 1'b0;
      open_row   <= '0;
      open_dirty <= 1'b0;
      rd_word    <= '0;
    end else if (start) begin
      if (!is_flush) buf_q <= line_new;
      rd_word <= is_flush ? '0 : pick_word(line_new, col);
      if (activate) begin
        open_valid <= 1'b1;
        open_row   <= row;
      end
      if (is_flush)      open_dirty <= 1'b0;
      else if (is_store) open_dirty <= 1'b1;
      else if (activate) open_dirty <= 1'b0;
    end
  end

  logic [ROW_W-1:0] unused_rw;
  assign unused_rw = '0;
endmodule

// File: rtl/rowbuf_dram_ctrl.sv
module rowbuf_dram_ctrl #(
  parameter int NUM_ROWS = 8,
  parameter int DLY_W    = 8,
  parameter int TAG_W    = 4,
  parameter int CORE_W   = 2,
  parameter int HIT_W    = 16,
  parameter int UPD_W    = 32,
  parameter int ADDR_W   = $clog2(NUM_ROWS) + drb_pkg::ROW_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DLY_W-1:0]  cfg_row_dly,
  input  logic [DLY_W-1:0]  cfg_col_dly,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [31:0]       cmd_wdata,
  input  logic [TAG_W-1:0]  cmd_tag,
  input  logic [CORE_W-1:0] cmd_core,
  output logic              done_valid,
  output logic [31:0]       done_rdata,
  output logic [TAG_W-1:0]  done_tag,
  output logic [CORE_W-1:0] done_core,
  output logic [HIT_W-1:0]  hit_count,
  output logic [UPD_W-1:0]  row_updates
);
  localparam int ROW_W = $clog2(NUM_ROWS);

  logic [ROW_W-1:0] acc_row;
  logic [7:0]       acc_col;
  logic             acc_fire;
  logic             pl_hit, pl_act, pl_wb, pl_store, pl_flush;
  logic             open_valid, open_dirty;
  logic [ROW_W-1:0] open_row;
  logic             unused_lsb;

  assign acc_row    = cmd_addr[ADDR_W-1:drb_pkg::ROW_SHIFT];
  assign acc_col    = cmd_addr[drb_pkg::ROW_SHIFT-1:2];
  assign unused_lsb = ^cmd_addr[1:0];
  assign acc_fire   = cmd_valid && cmd_ready;

  drb_access_plan #(.ROW_W(ROW_W)) plan_i (
    .op(cmd_op), .row(acc_row), .open_valid(open_valid), .open_row(open_row),
    .open_dirty(open_dirty), .hit(pl_hit), .activate(pl_act), .writeback(pl_wb),
    .is_store(pl_store), .is_flush(pl_flush)
  );

  drb_busy_timer #(.DLY_W(DLY_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .start(acc_fire), .activate(pl_act),
    .writeback(pl_wb), .is_flush(pl_flush), .row_dly(cfg_row_dly),
    .col_dly(cfg_col_dly), .idle(cmd_ready), .finish(done_valid)
  );

  drb_row_store #(.NUM_ROWS(NUM_ROWS)) store_i (
    .clk(clk), .rst_n(rst_n), .start(acc_fire), .activate(pl_act),
    .writeback(pl_wb), .is_store(pl_store), .is_flush(pl_flush),
    .row(acc_row), .col(acc_col), .wdata(cmd_wdata),
    .open_valid(open_valid), .open_row(open_row), .open_dirty(open_dirty),
    .rd_word(done_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_tag    <= '0;
      done_core   <= '0;
      hit_count   <= '0;
      row_updates <= '0;
    end else if (acc_fire) begin
      done_tag  <= cmd_tag;
      done_core <= cmd_core;
      if (pl_act)        hit_count <= HIT_W'(1);
      else if (!pl_flush) hit_count <= hit_count + HIT_W'(1);
      row_updates <= row_updates + UPD_W'(pl_act) + UPD_W'(pl_store);
    end
  end
endmodule

// File: rtl/drb_ctrl_chk.sv
module drb_ctrl_chk #(
  parameter int HIT_W = 16,
  parameter int UPD_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_ready,
  input logic             acc_fire,
  input logic             done_valid,
  input logic             pl_hit,
  input logic             pl_act,
  input logic             pl_store,
  input logic             pl_flush,
  input logic             open_dirty,
  input logic [HIT_W-1:0] hit_count,
  input logic [UPD_W-1:0] row_updates
);
  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> !cmd_ready);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);
  // R6
  hit_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && pl_act) |=> (hit_count == HIT_W'(1)));
  // R6
  hit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && pl_hit && !pl_flush) |=> (hit_count == HIT_W'($past(hit_count) + 1'b1)));
  // R7
  upd_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && pl_store && pl_hit) |=> (row_updates == UPD_W'($past(row_updates) + 1'b1)));
  // R4
  dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && pl_store) |=> open_dirty);
  // R8
  flush_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && pl_flush) |=> !open_dirty);
endmodule

bind rowbuf_dram_ctrl drb_ctrl_chk #(.HIT_W(HIT_W), .UPD_W(UPD_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .acc_fire(acc_fire),
  .done_valid(done_valid), .pl_hit(pl_hit), .pl_act(pl_act), .pl_store(pl_store),
  .pl_flush(pl_flush), .open_dirty(open_dirty), .hit_count(hit_count),
  .row_updates(row_updates)
);

// File: tb/rowbuf_dram_ctrl_tb_top.sv
`timescale 1ns/1ps
module rowbuf_dram_ctrl_tb_top;
  localparam int AW = 13;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_row_dly = 8'd6;
  logic [7:0]  cfg_col_dly = 8'd3;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'b00;
  logic [AW-1:0] cmd_addr = '0;
  logic [31:0] cmd_wdata = '0;
  logic [3:0]  cmd_tag = '0;
  logic [1:0]  cmd_core = '0;
  logic        done_valid;
  logic [31:0] done_rdata;
  logic [3:0]  done_tag;
  logic [1:0]  done_core;
  logic [15:0] hit_count;
  logic [31:0] row_updates;

  always #2.5 clk = ~clk;

  rowbuf_dram_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_row_dly(cfg_row_dly), .cfg_col_dly(cfg_col_dly),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_wdata(cmd_wdata), .cmd_tag(cmd_tag), .cmd_core(cmd_core),
    .done_valid(done_valid), .done_rdata(done_rdata), .done_tag(done_tag),
    .done_core(done_core), .hit_count(hit_count), .row_updates(row_updates)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mdl [int];
  bit   m_valid = 0;
  int   m_row = 0;
  bit   m_dirty = 0;
  int   m_hits = 0;
  int   m_upd = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issues one command, predicts its latency and results from the requirements,
  // optionally offers a conflicting store while busy (noise), and checks all outputs.
  task automatic do_cmd(input logic [1:0] op, input int addr, input logic [31:0] wd,
                        input logic [3:0] tag, input logic [1:0] core,
                        input string lat_req, input bit noise);
    int row, word, lat, k;
    bit hit;
    logic [31:0] exp_d;
    row  = addr >> 10;
    word = addr >> 2;
    if (op[1]) begin
      lat = 1 + ((m_valid && m_dirty) ? int'(cfg_row_dly) : 0);
      m_dirty = 0;
      exp_d = 32'd0;
    end else begin
      hit = m_valid && (m_row == row);
      lat = 1 + int'(cfg_col_dly);
      if (!hit) begin
        lat += int'(cfg_row_dly);
        if (m_valid && m_dirty) lat += int'(cfg_row_dly);
        m_valid = 1; m_row = row; m_dirty = 0; m_hits = 1; m_upd++;
      end else m_hits++;
      if (op[0]) begin
        mdl[word] = wd; m_dirty = 1; m_upd++; exp_d = wd;
      end else exp_d = mdl[word];
    end
    @(negedge clk);
    chk("R9 ready before command", {63'd0, cmd_ready}, 64'd1);
    cmd_valid = 1; cmd_op = op; cmd_addr = AW'(addr); cmd_wdata = wd;
    cmd_tag = tag; cmd_core = core;
    @(posedge clk);
    @(negedge clk);
    if (noise) begin
      cmd_op = 2'b01; cmd_wdata = ~wd; cmd_tag = ~tag;
    end else cmd_valid = 0;
    k = 0;
    while (k < 600) begin
      @(posedge clk);
      k++;
      @(negedge clk);
      if (done_valid) break;
    end
    cmd_valid = 0;
    chk(lat_req, 64'(k), 64'(lat));
    chk("R5 data", {32'd0, done_rdata}, {32'd0, exp_d});
    chk("R5 tag", {60'd0, done_tag}, {60'd0, tag});
    chk("R5 core", {62'd0, done_core}, {62'd0, core});
    chk("R6 hit count", {48'd0, hit_count}, 64'(m_hits));
    chk("R7 row updates", {32'd0, row_updates}, 64'(m_upd));
    @(negedge clk);
    chk("R9 done one cycle", {63'd0, done_valid}, 64'd0);
  endtask

  task automatic t_reset();
    chk("R10 ready", {63'd0, cmd_ready}, 64'd1);
    chk("R10 done", {63'd0, done_valid}, 64'd0);
    chk("R10 hits", {48'd0, hit_count}, 64'd0);
    chk("R10 updates", {32'd0, row_updates}, 64'd0);
  endtask

  task automatic t_first_and_hits();
    do_cmd(2'b01, 32'h014, 32'hA5A5_0001, 4'd1, 2'd0, "R3 first access no writeback", 0);
    do_cmd(2'b00, 32'h014, 32'h0, 4'd2, 2'd1, "R2 load hit", 0);
    do_cmd(2'b01, 32'h024, 32'h1234_5678, 4'd3, 2'd2, "R2 store hit", 0);
    do_cmd(2'b00, 32'h027, 32'h0, 4'd4, 2'd3, "R1 low bits ignored", 0);
  endtask

  task automatic t_row_change();
    do_cmd(2'b01, 32'h804, 32'hBEEF_0002, 4'd5, 2'd1, "R4 dirty miss", 0);
    do_cmd(2'b00, 32'h014, 32'h0, 4'd6, 2'd0, "R4 dirty miss back", 0);
    do_cmd(2'b00, 32'h804, 32'h0, 4'd7, 2'd2, "R3 clean miss", 0);
  endtask

  task automatic t_flush();
    do_cmd(2'b01, 32'h808, 32'hCAFE_0003, 4'd8, 2'd0, "R2 store hit", 0);
    do_cmd(2'b10, 32'h0, 32'h0, 4'd9, 2'd1, "R8 flush dirty", 0);
    do_cmd(2'b11, 32'h0, 32'h0, 4'd10, 2'd2, "R8 flush clean", 0);
    do_cmd(2'b00, 32'h014, 32'h0, 4'd11, 2'd3, "R8 miss after flush", 0);
    do_cmd(2'b00, 32'h808, 32'h0, 4'd12, 2'd0, "R8 flushed data kept", 0);
  endtask

  task automatic t_busy_ignore();
    do_cmd(2'b01, 32'h81C, 32'h0BAD_F00D, 4'd13, 2'd1, "R9 store while noise", 1);
    do_cmd(2'b00, 32'h81C, 32'h0, 4'd14, 2'd2, "R9 noise ignored", 0);
  endtask

  task automatic t_reprogram();
    @(negedge clk);
    cfg_row_dly = 8'd4; cfg_col_dly = 8'd2;
    do_cmd(2'b00, 32'h014, 32'h0, 4'd15, 2'd3, "R11 new delays miss", 0);
    do_cmd(2'b01, 32'h018, 32'h7777_0004, 4'd0, 2'd0, "R11 new delays hit", 0);
    do_cmd(2'b00, 32'hC00 + 32'h0, 32'h0, 4'd1, 2'd1, "R11 dirty miss", 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    mdl[32'hC00 >> 2] = 'x;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_first_and_hits();
    t_row_change();
    t_flush();
    t_busy_ignore();
    t_reprogram();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule